// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block models an eight-stage parallel-in, serial-out shift register in a fast system-clock domain. Its external pins (a shift clock, a clock-inhibit, an active-low shift/load, a serial input and an eight-bit parallel bus) are sampled as ordinary signals through two-flop synchronizers. While shift/load is low, the stages follow the parallel bus level by level. While it is high, the register shifts from stage A toward stage H whenever the OR of the two clock pins rises. Since the OR is symmetric, either pin can act as the clock while the other, held high, inhibits it.

Only the last stage (H) leaves the block, both true and complemented. Three sticky monitors check the timing rules of the pin interface. The first flags an inhibit pin that rises while the clock pin is low. The second flags a load pulse shorter than its minimum. The third flags a clock phase shorter than its minimum. The minimums are given in picoseconds and converted to system cycles through a period parameter.

Top module: `piso_gated_shifter`

## Requirements
- R1: While the synchronized shift/load is low, the stages copy the parallel bus (bit 0 = stage A, bit 7 = stage H) every system cycle, whatever the clock, inhibit and serial pins do.
- R2: With shift/load high, a low-to-high change of (clock OR inhibit) moves every stage one place toward H and loads stage A from the serial pin. After a load, successive clock pulses present H, G, F, E, D, C, B, A at the output, followed by the serial bits.
- R3: With shift/load high and no rising edge of (clock OR inhibit), all stages hold, even when the parallel and serial pins change.
- R4: While the inhibit pin is high, toggling the clock pin causes no shift.
- R5: The complemented output is always the inverse of the true output.
- R6: The inhibit violation flag sets, and stays set until reset, when the synchronized inhibit rises while the synchronized clock is low. That rise also acts as a shift edge.
- R7: The load width flag sets, and stays set until reset, when shift/load stays low for fewer than ceil(MIN_LOAD_PS / SYS_PERIOD_PS) system cycles. It is 2 cycles by default.
- R8: The clock width flag sets, and stays set until reset, when a high or a low phase of the clock pin lasts fewer than ceil(MIN_CLOCK_PS / SYS_PERIOD_PS) cycles. It is 3 cycles by default.
- R9: A synchronous active-high reset clears all stages to zero and clears all three flags. It takes the inhibit and shift/load synchronizers to their high state, so that leaving reset creates no edge and no violation.
- R10: A pin change, applied between system edges, reaches the outputs on the third rising system edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_clk | input | 1 | External shift clock pin |
| pin_inh | input | 1 | External clock-inhibit pin |
| pin_shld_n | input | 1 | Shift (high) / load (low) pin |
| pin_ser | input | 1 | Serial data into stage A |
| pin_par | input | WIDTH | Parallel data, bit 0 = stage A |
| out_last | output | 1 | Last stage (H), true |
| out_last_n | output | 1 | Last stage (H), complemented |
| inh_violation | output | 1 | Sticky: inhibit rose while clock low |
| load_width_err | output | 1 | Sticky: load pulse too short |
| clock_width_err | output | 1 | Sticky: clock phase too short |

## Verification
The main function is tried with a load held while the clock pin toggles, which shows that the level load overrides clocking. A full eight-pulse unload with a marked serial bit separates the correct H-to-A order from a reversed or off-by-one shift. The bench then tests inhibit-high toggling against an unblocked clock, and an inhibit-driven pulse, which checks that the pins are interchangeable and that the violation flag sets. Width monitors are driven at one cycle below and exactly at each minimum, for both clock phases, to pin the threshold.

// File: rtl/piso_gated_shifter.sv
module piso_gated_shifter #(
  parameter int WIDTH         = 8,
  parameter int SYS_PERIOD_PS = 10000,
  parameter int MIN_LOAD_PS   = 15000,
  parameter int MIN_CLOCK_PS  = 25000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_clk,
  input  logic             pin_inh,
  input  logic             pin_shld_n,
  input  logic             pin_ser,
  input  logic [WIDTH-1:0] pin_par,
  output logic             out_last,
  output logic             out_last_n,
  output logic             inh_violation,
  output logic             load_width_err,
  output logic             clock_width_err
);
  localparam int LD_CYC  = (MIN_LOAD_PS + SYS_PERIOD_PS - 1) / SYS_PERIOD_PS;
  localparam int CK_CYC  = (MIN_CLOCK_PS + SYS_PERIOD_PS - 1) / SYS_PERIOD_PS;
  localparam int MAX_CYC = (LD_CYC > CK_CYC) ? LD_CYC : CK_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] LD_LIM = CNT_W'(LD_CYC);
  localparam logic [CNT_W-1:0] CK_LIM = CNT_W'(CK_CYC);

  logic ck_m, ck_s, inh_m, inh_s, shld_m, shld_s, ser_m, ser_s;
  logic [WIDTH-1:0] par_m, par_s;
  logic or_q, inh_q, ck_q, shld_q;
  logic [WIDTH-1:0] stages;
  logic [CNT_W-1:0] ld_cnt, ck_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_m <= 1'b0;   ck_s <= 1'b0;
      inh_m <= 1'b1;  inh_s <= 1'b1;
      shld_m <= 1'b1; shld_s <= 1'b1;
      ser_m <= 1'b0;  ser_s <= 1'b0;
      par_m <= '0;    par_s <= '0;
    end else begin
      ck_m <= pin_clk;     ck_s <= ck_m;
      inh_m <= pin_inh;    inh_s <= inh_m;
      shld_m <= pin_shld_n; shld_s <= shld_m;
      ser_m <= pin_ser;    ser_s <= ser_m;
      par_m <= pin_par;    par_s <= par_m;
    end
  end

  wire gate_or   = ck_s | inh_s;
  wire shift_evt = shld_s & gate_or & ~or_q;
  wire inh_rise  = inh_s & ~inh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      or_q <= 1'b1; inh_q <= 1'b1; ck_q <= 1'b0; shld_q <= 1'b1;
    end else begin
      or_q <= gate_or; inh_q <= inh_s; ck_q <= ck_s; shld_q <= shld_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            stages <= '0;
    else if (!shld_s)   stages <= par_s;
    else if (shift_evt) stages <= {stages[WIDTH-2:0], ser_s};
  end

  always_ff @(posedge clk) begin
    if (rst)                     inh_violation <= 1'b0;
    else if (inh_rise && !ck_s)  inh_violation <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_cnt <= LD_LIM;
      load_width_err <= 1'b0;
    end else if (!shld_s && shld_q) begin
      ld_cnt <= 1;
    end else if (shld_s && !shld_q) begin
      if (ld_cnt < LD_LIM) load_width_err <= 1'b1;
    end else if (!shld_s && ld_cnt < LD_LIM) begin
      ld_cnt <= ld_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_cnt <= CK_LIM;
      clock_width_err <= 1'b0;
    end else if (ck_s != ck_q) begin
      if (ck_cnt < CK_LIM) clock_width_err <= 1'b1;
      ck_cnt <= 1;
    end else if (ck_cnt < CK_LIM) begin
      ck_cnt <= ck_cnt + 1'b1;
    end
  end

  assign out_last   = stages[WIDTH-1];
  assign out_last_n = ~stages[WIDTH-1];
endmodule

// File: rtl/piso_gated_shifter_chk.sv
module piso_gated_shifter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             shld_s,
  input logic             ck_s,
  input logic             inh_s,
  input logic             shift_evt,
  input logic [WIDTH-1:0] par_s,
  input logic [WIDTH-1:0] stages,
  input logic             out_last,
  input logic             inh_violation,
  input logic             load_width_err,
  input logic             clock_width_err
);
  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    !shld_s |=> stages == $past(par_s));

  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> out_last == $past(stages[WIDTH-2]));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (shld_s && !shift_evt) |=> $stable(stages));

  p_inhibit_r4: assert property (@(posedge clk) disable iff (rst)
    (shld_s && inh_s && $past(inh_s)) |=> $stable(stages));

  p_viol_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    inh_violation |=> inh_violation);

  p_viol_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(inh_violation) |-> ($past(inh_s) && !$past(ck_s)));

  p_ldw_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    load_width_err |=> load_width_err);

  p_ckw_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    clock_width_err |=> clock_width_err);

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (stages == '0 && !inh_violation && !load_width_err && !clock_width_err));
endmodule

bind piso_gated_shifter piso_gated_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .shld_s(shld_s), .ck_s(ck_s), .inh_s(inh_s),
  .shift_evt(shift_evt), .par_s(par_s), .stages(stages), .out_last(out_last),
  .inh_violation(inh_violation), .load_width_err(load_width_err),
  .clock_width_err(clock_width_err)
);

// File: tb/piso_gated_shifter_bench.sv
module piso_gated_shifter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_clk = 1'b0, pin_inh = 1'b0, pin_shld_n = 1'b1, pin_ser = 1'b0;
  logic [W-1:0] pin_par = '0;
  logic out_last, out_last_n, inh_violation, load_width_err, clock_width_err;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  piso_gated_shifter #(.WIDTH(W), .SYS_PERIOD_PS(CLK_PERIOD*1000)) u_piso_gated_shifter (
    .clk(clk), .rst(rst), .pin_clk(pin_clk), .pin_inh(pin_inh),
    .pin_shld_n(pin_shld_n), .pin_ser(pin_ser), .pin_par(pin_par),
    .out_last(out_last), .out_last_n(out_last_n), .inh_violation(inh_violation),
    .load_width_err(load_width_err), .clock_width_err(clock_width_err)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic exp);
    chk(req, {31'd0, out_last}, {31'd0, exp});
    chk("R5 complement", {31'd0, out_last_n}, {31'd0, ~out_last});
  endtask

  task automatic clk_pulse;
    pin_clk = 1'b1; tick(4);
    pin_clk = 1'b0; tick(4);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    pin_clk = 1'b0; pin_inh = 1'b0; pin_shld_n = 1'b1; pin_ser = 1'b0; pin_par = '0;
    tick(3);
    rst = 1'b0;
    tick(4);
  endtask

  task automatic t_reset;
    do_reset();
    chk_out("R9 stages cleared", 1'b0);
    chk("R9 inh flag", {31'd0, inh_violation}, 32'd0);
    chk("R9 load flag", {31'd0, load_width_err}, 32'd0);
    chk("R9 clock flag", {31'd0, clock_width_err}, 32'd0);
  endtask

  task automatic t_load;
    pin_par = 8'b1011_0010;
    pin_shld_n = 1'b0;
    tick(2);
    chk_out("R10 not yet loaded", 1'b0);
    tick(1);
    chk_out("R10 R1 loaded on third edge", 1'b1);
    pin_clk = 1'b1; pin_ser = 1'b1; pin_par = 8'h35;
    tick(4);
    chk_out("R1 load overrides clock", 1'b0);
    pin_clk = 1'b0; tick(4);
    pin_shld_n = 1'b1; tick(4);
    chk_out("R1 value kept after load", 1'b0);
  endtask

  task automatic t_shift;
    logic [W-1:0] v = 8'h35;
    pin_ser = 1'b1;
    for (int i = W-2; i >= 0; i--) begin
      clk_pulse();
      chk_out("R2 unload order", v[i]);
    end
    pin_ser = 1'b0;
    clk_pulse();
    chk_out("R2 serial bit reaches H", 1'b1);
  endtask

  task automatic t_hold;
    pin_par = 8'h00; pin_ser = 1'b0;
    tick(6);
    chk_out("R3 hold without edge", 1'b1);
  endtask

  task automatic t_inhibit;
    pin_par = 8'hA5; pin_clk = 1'b1; pin_shld_n = 1'b0; tick(4);
    pin_shld_n = 1'b1; tick(4);
    pin_inh = 1'b1; tick(4);
    for (int k = 0; k < 2; k++) begin
      pin_clk = 1'b0; tick(4);
      pin_clk = 1'b1; tick(4);
    end
    chk_out("R4 no shift while inhibited", 1'b1);
    chk("R6 legal inhibit rise", {31'd0, inh_violation}, 32'd0);
    pin_inh = 1'b0; tick(4);
    pin_clk = 1'b0; tick(4);
    chk_out("R2 clock fall does not shift", 1'b1);
    pin_clk = 1'b1; tick(4);
    chk_out("R2 shift after inhibit released", 1'b0);
  endtask

  task automatic t_alt_clock;
    pin_clk = 1'b0; tick(4);
    pin_inh = 1'b1; tick(4);
    chk_out("R6 inhibit pin acts as clock", 1'b1);
    chk("R6 violation set", {31'd0, inh_violation}, 32'd1);
    pin_inh = 1'b0; tick(4);
    chk("R6 violation sticky", {31'd0, inh_violation}, 32'd1);
    do_reset();
    chk("R9 violation cleared", {31'd0, inh_violation}, 32'd0);
  endtask

  task automatic t_widths;
    pin_shld_n = 1'b0; tick(1); pin_shld_n = 1'b1; tick(4);
    chk("R7 one-cycle load flagged", {31'd0, load_width_err}, 32'd1);
    do_reset();
    pin_shld_n = 1'b0; tick(2); pin_shld_n = 1'b1; tick(4);
    chk("R7 minimum load accepted", {31'd0, load_width_err}, 32'd0);
    pin_clk = 1'b1; tick(2); pin_clk = 1'b0; tick(4);
    chk("R8 short high phase flagged", {31'd0, clock_width_err}, 32'd1);
    do_reset();
    pin_clk = 1'b1; tick(3); pin_clk = 1'b0; tick(4);
    chk("R8 minimum high phase accepted", {31'd0, clock_width_err}, 32'd0);
    pin_clk = 1'b1; tick(4); pin_clk = 1'b0; tick(2); pin_clk = 1'b1; tick(4);
    chk("R8 short low phase flagged", {31'd0, clock_width_err}, 32'd1);
  endtask

  initial begin
    t_reset();
    t_load();
    t_shift();
    t_hold();
    t_inhibit();
    t_alt_clock();
    t_widths();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule